// File: doc/BRIEF.md
# Partial-Word Load/Store Lane Unit

This unit sits between the execute stage of a 32-bit core and a little-endian word memory. For each retiring memory instruction it steers byte and halfword lanes, extends loaded values with sign or zero, and flags accesses that are not aligned to their size. It also merges lanes for the unaligned left and right word loads and stores. Partial stores return a full aligned word and a byte-enable mask. The left and right stores are a read-modify-write of the aligned word that the core has already fetched.

The unit also holds a one-deep delayed-load slot. A load is committed to the register file during the next retiring instruction, not its own. A left or right load that names the register held in the slot merges into the value still in flight, not into the stale register-file copy. A retire that raises an exception still commits the slot, then leaves it empty.

Top module: `lsu_lane_unit`

## Requirements
- R1: Byte loads take the byte at lane addr_i[1:0], with lane 0 in bits 7:0. Op code 1 copies bit 7 of that byte into bits 31:8. Op code 2 clears bits 31:8.
- R2: Halfword loads take bits 15:0 when addr_i[1] is 0 and bits 31:16 when it is 1. Op code 3 copies bit 15 into the upper half and op code 4 clears it. A word load (op code 5) returns the whole memory word.
- R3: An access is misaligned when it is a halfword op (3, 4, 9) with addr_i[0] set, or a word op (5, 10) with addr_i[1:0] not zero. A misaligned retire raises addr_err_o, puts addr_i on bad_addr_o, writes nothing to memory and records no load. bad_addr_o is zero otherwise.
- R4: Load-left (op code 6) keyed by addr_i[1:0]: 0 gives the memory word; 1 gives {mem[23:0], old[7:0]}; 2 gives {mem[15:0], old[15:0]}; 3 gives {mem[7:0], old[23:0]}.
- R5: Load-right (op code 7) keyed by addr_i[1:0]: 0 gives {old[31:8], mem[31:24]}; 1 gives {old[31:16], mem[31:16]}; 2 gives {old[31:24], mem[31:8]}; 3 gives the memory word.
- R6: Store-left (op code 11) writes the aligned word with all four enables: 0 gives rt; 1 gives {mem[31:24], rt[31:8]}; 2 gives {mem[31:16], rt[31:16]}; 3 gives {mem[31:8], rt[31:24]}.
- R7: Store-right (op code 12) writes the aligned word with all four enables: 0 gives {rt[7:0], mem[23:0]}; 1 gives {rt[15:0], mem[15:0]}; 2 gives {rt[23:0], mem[7:0]}; 3 gives rt.
- R8: The old value for op codes 6 and 7 is the pending load data when a pending load targets rt_idx_i. Otherwise it is rt_val_i.
- R9: During a retire (valid_i high), the wb outputs present the pending load. At the end of that retire, the slot takes the retiring load, or becomes empty if there is none. A cycle with valid_i low changes neither the slot nor the memory outputs.
- R10: A pending load whose destination is register 0 never raises wb_en_o.
- R11: A retire with exc_i high still commits the pending load. It records no new load and writes no memory.
- R12: A byte store (op code 8) writes rt[7:0] on every lane, with a single enable at lane addr_i[1:0]. A halfword store (op code 9) writes rt[15:0] in both halves, with enables 0011 or 1100 chosen by addr_i[1]. A word store (op code 10) writes rt with enables 1111. When mem_we_o is low, data and enables are zero.
- R13: After reset no load is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction retires this cycle |
| op_i | input | 4 | Access type: 0 none, 1..7 loads, 8..12 stores (codes per requirements) |
| exc_i | input | 1 | The retiring instruction takes an exception |
| addr_i | input | 32 | Effective byte address |
| rt_idx_i | input | 5 | Load destination / store source register index |
| rt_val_i | input | 32 | Register-file value of rt |
| mem_rdata_i | input | 32 | Aligned memory word at addr_i |
| mem_wdata_o | output | 32 | Word to write |
| mem_be_o | output | 4 | Byte enables, bit n for bits 8n+7:8n |
| mem_we_o | output | 1 | Memory write |
| load_data_o | output | 32 | Extended or merged load result |
| addr_err_o | output | 1 | Misaligned access |
| bad_addr_o | output | 32 | Faulting address |
| wb_en_o | output | 1 | Commit pending load to register file |
| wb_idx_o | output | 5 | Commit destination |
| wb_data_o | output | 32 | Commit value |
| pend_valid_o | output | 1 | A load is pending |
| pend_idx_o | output | 5 | Pending destination |
| pend_data_o | output | 32 | Pending value |

## Verification
The assertions assume that the inputs only carry meaning when valid_i is high. They also assume mem_rdata_i already holds the aligned word for addr_i, and that op_i only takes the codes listed. The bench drives only those codes, changes inputs at the falling edge, and supplies a word memory value with every step. Steps with valid_i low are driven so that the slot-hold check sees real idle cycles. Register 0 is never used as a merge target, so the undefined merge into a discarded register does not arise.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [3:0] {
    LS_NONE = 4'd0,
    LS_LB   = 4'd1,
    LS_LBU  = 4'd2,
    LS_LH   = 4'd3,
    LS_LHU  = 4'd4,
    LS_LW   = 4'd5,
    LS_LWL  = 4'd6,
    LS_LWR  = 4'd7,
    LS_SB   = 4'd8,
    LS_SH   = 4'd9,
    LS_SW   = 4'd10,
    LS_SWL  = 4'd11,
    LS_SWR  = 4'd12
  } ls_op_e;

  function automatic logic op_is_load(ls_op_e op);
    return op inside {LS_LB, LS_LBU, LS_LH, LS_LHU, LS_LW, LS_LWL, LS_LWR};
  endfunction

  function automatic logic op_is_store(ls_op_e op);
    return op inside {LS_SB, LS_SH, LS_SW, LS_SWL, LS_SWR};
  endfunction
endpackage

// File: rtl/lsu_load_align.sv
module lsu_load_align import lsu_pkg::*; #(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OFF_W = $clog2(NB),
  localparam int SH_W = $clog2(XLEN)
) (
  input  ls_op_e           op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [XLEN-1:0]  mem_i,
  input  logic [XLEN-1:0]  old_i,
  output logic [XLEN-1:0]  res_o
);
  localparam logic [XLEN-1:0] ONES = '1;

  logic [SH_W-1:0] byte_sh, half_sh, rev_sh;
  logic [XLEN-1:0] byte_w, half_w;

  always_comb begin
    byte_sh = {off_i, 3'b000};
    half_sh = {off_i[OFF_W-1:1], 4'b0000};
    rev_sh  = {~off_i, 3'b000};
    byte_w  = mem_i >> byte_sh;
    half_w  = mem_i >> half_sh;
    unique case (op_i)
      LS_LB:   res_o = {{(XLEN-8){byte_w[7]}}, byte_w[7:0]};
      LS_LBU:  res_o = {{(XLEN-8){1'b0}}, byte_w[7:0]};
      LS_LH:   res_o = {{(XLEN-16){half_w[15]}}, half_w[15:0]};
      LS_LHU:  res_o = {{(XLEN-16){1'b0}}, half_w[15:0]};
      LS_LW:   res_o = mem_i;
      // memory fills from the top down to the addressed lane
      LS_LWL:  res_o = (mem_i << byte_sh) | (old_i & ~(ONES << byte_sh));
      // memory fills from the bottom up to the addressed lane
      LS_LWR:  res_o = (mem_i >> rev_sh) | (old_i & ~(ONES >> rev_sh));
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align import lsu_pkg::*; #(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OFF_W = $clog2(NB),
  localparam int SH_W = $clog2(XLEN)
) (
  input  ls_op_e           op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [XLEN-1:0]  mem_i,
  output logic [XLEN-1:0]  wdata_o,
  output logic [NB-1:0]    be_o
);
  localparam logic [XLEN-1:0] ONES = '1;
  localparam logic [NB-1:0] BE_ONE = {{(NB-1){1'b0}}, 1'b1};
  localparam logic [NB-1:0] BE_TWO = {{(NB-2){1'b0}}, 2'b11};

  logic [SH_W-1:0] byte_sh, rev_sh;
  logic [OFF_W-1:0] half_off;

  always_comb begin
    byte_sh  = {off_i, 3'b000};
    rev_sh   = {~off_i, 3'b000};
    half_off = {off_i[OFF_W-1:1], 1'b0};
    be_o     = '1;
    unique case (op_i)
      LS_SB: begin
        wdata_o = {NB{rt_i[7:0]}};
        be_o    = BE_ONE << off_i;
      end
      LS_SH: begin
        wdata_o = {(NB/2){rt_i[15:0]}};
        be_o    = BE_TWO << half_off;
      end
      LS_SW:   wdata_o = rt_i;
      LS_SWL:  wdata_o = (rt_i >> byte_sh) | (mem_i & ~(ONES >> byte_sh));
      LS_SWR:  wdata_o = (rt_i << rev_sh) | (mem_i & ~(ONES << rev_sh));
      default: begin
        wdata_o = '0;
        be_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/lsu_pend_slot.sv
module lsu_pend_slot #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]   data_i,
  output logic              valid_o,
  output logic [RIDX_W-1:0] idx_o,
  output logic [XLEN-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      data_o  <= '0;
    end else if (step_i) begin
      valid_o <= load_i;
      idx_o   <= idx_i;
      data_o  <= data_i;
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit import lsu_pkg::*; #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  localparam int NB = XLEN / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              exc_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [RIDX_W-1:0] rt_idx_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic [NB-1:0]     mem_be_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   load_data_o,
  output logic              addr_err_o,
  output logic [XLEN-1:0]   bad_addr_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              pend_valid_o,
  output logic [RIDX_W-1:0] pend_idx_o,
  output logic [XLEN-1:0]   pend_data_o
);
  ls_op_e           op;
  logic [OFF_W-1:0] off;
  logic             misal, half_op, word_op, new_load;
  logic [XLEN-1:0]  old_val, st_data;
  logic [NB-1:0]    st_be;

  assign op      = ls_op_e'(op_i);
  assign off     = addr_i[OFF_W-1:0];
  assign half_op = op inside {LS_LH, LS_LHU, LS_SH};
  assign word_op = op inside {LS_LW, LS_SW};
  assign misal   = (half_op && addr_i[0]) || (word_op && (off != '0));

  assign addr_err_o = valid_i && misal;
  assign bad_addr_o = addr_err_o ? addr_i : '0;

  // merge base follows the in-flight load when it targets the same register
  assign old_val = (pend_valid_o && (pend_idx_o == rt_idx_i)) ? pend_data_o : rt_val_i;

  lsu_load_align #(.XLEN(XLEN)) i_load_align (
    .op_i  (op),
    .off_i (off),
    .mem_i (mem_rdata_i),
    .old_i (old_val),
    .res_o (load_data_o)
  );

  lsu_store_align #(.XLEN(XLEN)) i_store_align (
    .op_i    (op),
    .off_i   (off),
    .rt_i    (rt_val_i),
    .mem_i   (mem_rdata_i),
    .wdata_o (st_data),
    .be_o    (st_be)
  );

  assign mem_we_o    = valid_i && op_is_store(op) && !misal && !exc_i;
  assign mem_wdata_o = mem_we_o ? st_data : '0;
  assign mem_be_o    = mem_we_o ? st_be : '0;

  assign new_load = op_is_load(op) && !misal && !exc_i;

  lsu_pend_slot #(.XLEN(XLEN), .RIDX_W(RIDX_W)) i_pend_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (valid_i),
    .load_i  (new_load),
    .idx_i   (rt_idx_i),
    .data_i  (load_data_o),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o),
    .data_o  (pend_data_o)
  );

  // register 0 is never written back
  assign wb_en_o   = valid_i && pend_valid_o && (pend_idx_o != '0);
  assign wb_idx_o  = pend_idx_o;
  assign wb_data_o = pend_data_o;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk import lsu_pkg::*; #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  localparam int NB = XLEN / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              exc_i,
  input logic [RIDX_W-1:0] rt_idx_i,
  input logic [NB-1:0]     mem_be_o,
  input logic              mem_we_o,
  input logic [XLEN-1:0]   load_data_o,
  input logic              addr_err_o,
  input logic              wb_en_o,
  input logic [RIDX_W-1:0] wb_idx_o,
  input logic              pend_valid_o,
  input logic [RIDX_W-1:0] pend_idx_o,
  input logic [XLEN-1:0]   pend_data_o
);
  logic is_ld;
  assign is_ld = op_is_load(ls_op_e'(op_i));

  a_r3_err_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !mem_we_o);

  a_r10_no_zero_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != '0));

  a_r9_load_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_ld && !addr_err_o && !exc_i) |=>
      (pend_valid_o && pend_idx_o == $past(rt_idx_i) && pend_data_o == $past(load_data_o)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pend_valid_o) && $stable(pend_data_o) && $stable(pend_idx_o)));

  a_r11_exc_drops_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && exc_i) |=> !pend_valid_o);

  a_r12_byte_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_i == LS_SB) |-> ($countones(mem_be_o) == 1));
endmodule

bind lsu_lane_unit lsu_lane_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) i_lsu_lane_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .op_i         (op_i),
  .exc_i        (exc_i),
  .rt_idx_i     (rt_idx_i),
  .mem_be_o     (mem_be_o),
  .mem_we_o     (mem_we_o),
  .load_data_o  (load_data_o),
  .addr_err_o   (addr_err_o),
  .wb_en_o      (wb_en_o),
  .wb_idx_o     (wb_idx_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o),
  .pend_data_o  (pend_data_o)
);

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;
  import lsu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        exc_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [4:0]  rt_idx_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] mem_wdata_o, load_data_o, bad_addr_o, wb_data_o, pend_data_o;
  logic [3:0]  mem_be_o;
  logic        mem_we_o, addr_err_o, wb_en_o, pend_valid_o;
  logic [4:0]  wb_idx_o, pend_idx_o;

  always #2 clk = ~clk;

  lsu_lane_unit i_lsu_lane_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .exc_i(exc_i),
    .addr_i(addr_i), .rt_idx_i(rt_idx_i), .rt_val_i(rt_val_i), .mem_rdata_i(mem_rdata_i),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_we_o(mem_we_o),
    .load_data_o(load_data_o), .addr_err_o(addr_err_o), .bad_addr_o(bad_addr_o),
    .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
    .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o), .pend_data_o(pend_data_o)
  );

  typedef struct {
    logic [31:0] ld, wd, bad, wb_d;
    logic [3:0]  be;
    logic        we, err, wb_en, chk_ld;
    logic [4:0]  wb_idx;
    string       tag;
  } exp_t;

  exp_t  sb_q[$];
  event  drv_ev;
  int    n_chk = 0, n_fail = 0;

  // bench-side model of the pending slot
  logic        m_pv = 1'b0;
  logic [4:0]  m_pi = '0;
  logic [31:0] m_pd = '0;

  task automatic drive(input ls_op_e op, input logic [31:0] addr, input logic [4:0] idx,
                       input logic [31:0] rtv, input logic [31:0] mem, input logic exc,
                       input logic vld, input string tag);
    exp_t e;
    logic [31:0] old;
    logic [1:0]  k;
    logic        mis, ld_op, st_op;
    logic [7:0]  b;
    logic [15:0] h;
    @(negedge clk);
    valid_i = vld; op_i = op; addr_i = addr; rt_idx_i = idx;
    rt_val_i = rtv; mem_rdata_i = mem; exc_i = exc;
    k     = addr[1:0];
    old   = (m_pv && m_pi == idx) ? m_pd : rtv;
    ld_op = (op == LS_LB) || (op == LS_LBU) || (op == LS_LH) || (op == LS_LHU) ||
            (op == LS_LW) || (op == LS_LWL) || (op == LS_LWR);
    st_op = (op == LS_SB) || (op == LS_SH) || (op == LS_SW) || (op == LS_SWL) || (op == LS_SWR);
    mis   = (((op == LS_LH) || (op == LS_LHU) || (op == LS_SH)) && addr[0]) ||
            (((op == LS_LW) || (op == LS_SW)) && k != 2'd0);
    b = mem[8*k +: 8];
    h = mem[16*addr[1] +: 16];
    e.tag = tag;
    e.err = vld && mis;
    e.bad = e.err ? addr : 32'h0;
    e.ld  = 32'h0;
    case (op)
      LS_LB:  e.ld = {{24{b[7]}}, b};
      LS_LBU: e.ld = {24'h0, b};
      LS_LH:  e.ld = {{16{h[15]}}, h};
      LS_LHU: e.ld = {16'h0, h};
      LS_LW:  e.ld = mem;
      LS_LWL: case (k)
        2'd0: e.ld = mem;
        2'd1: e.ld = {mem[23:0], old[7:0]};
        2'd2: e.ld = {mem[15:0], old[15:0]};
        default: e.ld = {mem[7:0], old[23:0]};
      endcase
      LS_LWR: case (k)
        2'd0: e.ld = {old[31:8], mem[31:24]};
        2'd1: e.ld = {old[31:16], mem[31:16]};
        2'd2: e.ld = {old[31:24], mem[31:8]};
        default: e.ld = mem;
      endcase
      default: e.ld = 32'h0;
    endcase
    e.chk_ld = ld_op && !mis;
    e.we = vld && st_op && !mis && !exc;
    e.wd = 32'h0; e.be = 4'h0;
    if (e.we) begin
      e.be = 4'hf;
      case (op)
        LS_SB: begin e.wd = {4{rtv[7:0]}}; e.be = 4'b0001 << k; end
        LS_SH: begin e.wd = {2{rtv[15:0]}}; e.be = addr[1] ? 4'b1100 : 4'b0011; end
        LS_SW: e.wd = rtv;
        LS_SWL: case (k)
          2'd0: e.wd = rtv;
          2'd1: e.wd = {mem[31:24], rtv[31:8]};
          2'd2: e.wd = {mem[31:16], rtv[31:16]};
          default: e.wd = {mem[31:8], rtv[31:24]};
        endcase
        default: case (k)
          2'd0: e.wd = {rtv[7:0], mem[23:0]};
          2'd1: e.wd = {rtv[15:0], mem[15:0]};
          2'd2: e.wd = {rtv[23:0], mem[7:0]};
          default: e.wd = rtv;
        endcase
      endcase
    end
    e.wb_en  = vld && m_pv && m_pi != 5'd0;
    e.wb_idx = m_pi;
    e.wb_d   = m_pd;
    sb_q.push_back(e);
    ->drv_ev;
    if (vld) begin
      m_pv = ld_op && !mis && !exc;
      m_pi = idx;
      m_pd = e.ld;
    end
  endtask

  // monitor: compares outputs mid-cycle, after the driver has settled inputs
  initial forever begin
    exp_t e;
    logic bad;
    @(drv_ev);
    #1;
    e = sb_q.pop_front();
    bad = (mem_we_o !== e.we) || (mem_wdata_o !== e.wd) || (mem_be_o !== e.be) ||
          (addr_err_o !== e.err) || (bad_addr_o !== e.bad) || (wb_en_o !== e.wb_en) ||
          (e.wb_en && ((wb_idx_o !== e.wb_idx) || (wb_data_o !== e.wb_d))) ||
          (e.chk_ld && (load_data_o !== e.ld));
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: ld=%h/%h wd=%h/%h be=%b/%b we=%b/%b err=%b/%b bad=%h/%h wb=%b,%0d,%h/%b,%0d,%h",
               e.tag, load_data_o, e.ld, mem_wdata_o, e.wd, mem_be_o, e.be, mem_we_o, e.we,
               addr_err_o, e.err, bad_addr_o, e.bad, wb_en_o, wb_idx_o, wb_data_o,
               e.wb_en, e.wb_idx, e.wb_d);
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: nothing pending out of reset
    n_chk++;
    if (pend_valid_o !== 1'b0 || wb_en_o !== 1'b0 || mem_we_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: pend=%b wb=%b we=%b expected 0 0 0", pend_valid_o, wb_en_o, mem_we_o);
    end
    rst_ni = 1'b1;
    drive(LS_LB,  32'h0000_1001, 5'd3, 32'h0, 32'h1234_8578, 0, 1, "R13 R1 signed byte");
    drive(LS_LBU, 32'h0000_1003, 5'd4, 32'h0, 32'h1234_8578, 0, 1, "R1 R9 unsigned byte");
    drive(LS_LB,  32'h0000_1000, 5'd8, 32'h0, 32'h1234_8578, 0, 1, "R1 positive byte");
    drive(LS_LH,  32'h0000_2002, 5'd6, 32'h0, 32'h8001_c0de, 0, 1, "R2 signed half");
    drive(LS_LHU, 32'h0000_2000, 5'd7, 32'h0, 32'h8001_c0de, 0, 1, "R2 unsigned half");
    drive(LS_LH,  32'h0000_2003, 5'd6, 32'h0, 32'h8001_c0de, 0, 1, "R3 misaligned half");
    drive(LS_LW,  32'h0000_0100, 5'd0, 32'h0, 32'hdead_beef, 0, 1, "R3 nothing recorded");
    drive(LS_SW,  32'h0000_0104, 5'd2, 32'hcafe_f00d, 32'h0, 0, 1, "R10 R12 word store");
    drive(LS_LW,  32'h0000_0200, 5'd5, 32'h0, 32'h1122_3344, 0, 1, "R2 word load");
    drive(LS_LWL, 32'h0000_0201, 5'd5, 32'h0, 32'haabb_ccdd, 0, 1, "R4 R8 left from pending");
    drive(LS_LWR, 32'h0000_0202, 5'd9, 32'h0102_0304, 32'ha1b2_c3d4, 0, 1, "R5 R8 right from reg");
    drive(LS_LWL, 32'h0000_0203, 5'd9, 32'hffff_ffff, 32'h5566_7788, 0, 1, "R4 left lane 3");
    drive(LS_LWR, 32'h0000_0200, 5'd10, 32'h9999_9999, 32'h5566_7788, 0, 1, "R5 right lane 0");
    drive(LS_LWL, 32'h0000_0202, 5'd11, 32'h7777_7777, 32'h5566_7788, 0, 1, "R4 left lane 2");
    drive(LS_LWR, 32'h0000_0203, 5'd12, 32'h7777_7777, 32'h5566_7788, 0, 1, "R5 right lane 3");
    drive(LS_SWL, 32'h0000_0301, 5'd1, 32'ha1b2_c3d4, 32'h1122_3344, 0, 1, "R6 store-left 1");
    drive(LS_SWL, 32'h0000_0303, 5'd1, 32'ha1b2_c3d4, 32'h1122_3344, 0, 1, "R6 store-left 3");
    drive(LS_SWR, 32'h0000_0300, 5'd1, 32'ha1b2_c3d4, 32'h1122_3344, 0, 1, "R7 store-right 0");
    drive(LS_SWR, 32'h0000_0302, 5'd1, 32'ha1b2_c3d4, 32'h1122_3344, 0, 1, "R7 store-right 2");
    drive(LS_SB,  32'h0000_0402, 5'd1, 32'h0000_00ab, 32'h0, 0, 1, "R12 byte store");
    drive(LS_SH,  32'h0000_0402, 5'd1, 32'h0000_1234, 32'h0, 0, 1, "R12 half store hi");
    drive(LS_SH,  32'h0000_0400, 5'd1, 32'h0000_5678, 32'h0, 0, 1, "R12 half store lo");
    drive(LS_SH,  32'h0000_0401, 5'd1, 32'h0000_1234, 32'h0, 0, 1, "R3 misaligned half store");
    drive(LS_SW,  32'h0000_0402, 5'd1, 32'h0000_1234, 32'h0, 0, 1, "R3 misaligned word store");
    drive(LS_LW,  32'h0000_0500, 5'd11, 32'h0, 32'h0bad_f00d, 0, 1, "R11 setup");
    drive(LS_LW,  32'h0000_0504, 5'd12, 32'h0, 32'h1357_9bdf, 1, 1, "R11 exception commits");
    drive(LS_SW,  32'h0000_0508, 5'd1, 32'h1111_1111, 32'h0, 1, 1, "R11 no commit, no write");
    drive(LS_LW,  32'h0000_0600, 5'd13, 32'h0, 32'h2468_ace0, 0, 1, "R9 load before idle");
    drive(LS_NONE, 32'h0, 5'd0, 32'h0, 32'h0, 0, 0, "R9 idle no commit");
    drive(LS_NONE, 32'h0, 5'd0, 32'h0, 32'h0, 0, 0, "R9 idle again");
    drive(LS_NONE, 32'h0, 5'd1, 32'h0, 32'h0, 0, 1, "R9 commit after idle");
    drive(LS_NONE, 32'h0, 5'd1, 32'h0, 32'h0, 0, 1, "R9 slot empty");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule